// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a single-data-rate synchronous DRAM interface. On every rising clock edge it samples the clock-enable, chip-select, row strobe, column strobe, write-enable, bank-select and address pins. It classifies what the controller asked for and reports that as a four-bit command code. It keeps an open/closed flag and the opened row for each of two banks, and it holds the three mode fields that a mode-register load programs. A column access aimed at a closed bank produces a one-cycle error pulse.

The clock-enable value from the previous edge is paired with the current one. This pairing separates auto refresh from self-refresh entry, and it detects entry into and exit from power-down and clock suspend. While the clock is held off, internal progress freezes. A single burst tracker counts the beats of the current read or write burst. When an auto-precharge was requested, it closes that burst's bank at the end of the burst, at a burst stop, or when another column command interrupts the burst.

All outputs are registered. A command sampled at edge t is visible from edge t onward, until edge t+1.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With clock-enable high at both the previous and the current edge and chip-select low, the pin pattern {ras_n,cas_n,we_n} decodes as follows. 000 is mode load (code 13). 011 is activate (code 1). 101 is read (code 2, or 14 when addr[10]=1). 100 is write (code 3, or 15 when addr[10]=1). 010 is precharge (code 4, or 5 when addr[10]=1). 110 is burst stop (code 6). 001 is auto refresh (code 7). 111 is no-op (code 0). The code appears on cmd_code after the sampling edge.
- R2: Chip-select high with clock-enable high at both edges gives code 0. It alters no bank flag, row or mode field, whatever the other pins carry.
- R3: The refresh pattern gives code 7 when clock-enable is high at both edges. It gives code 8 (self-refresh entry) when clock-enable was high at the previous edge and is low now.
- R4: Clock-enable going from high to low on any other pattern gives code 9 (power-down) when no bank is open, or code 10 (clock suspend) when a bank is open. The command on the pins is not executed. Clock-enable low at both edges gives code 12. Going from low to high gives code 11. Neither of these changes any bank state.
- R5: Activate sets the flag of bank ba and stores addr[10:0] as that bank's row. Bank i's row sits at bank_row[11*i+10:11*i].
- R6: Precharge with addr[10]=0 closes bank ba. Precharge with addr[10]=1 closes both banks.
- R7: A read or write to a closed bank raises err_pulse for exactly one cycle. The command is ignored: no burst starts, and a burst in progress keeps counting.
- R8: A read or write with addr[10]=1 to an open bank closes that bank BL edges after the command edge, where BL is the programmed burst length.
- R9: Burst length code 0 gives 1 beat, code 1 gives 2, code 2 gives 4, code 3 gives 8 and code 7 gives a full page of 512 beats. Codes 4, 5 and 6 give 1 beat. Beats advance only on edges where clock-enable is high at both the previous and the current edge.
- R10: Mode load copies addr[2:0] to burst_len, addr[3] to burst_interleave and addr[6:4] to cas_latency. Any other cycle leaves them unchanged.
- R11: Burst stop, or an accepted read or write, ends the current burst. A pending auto-precharge then closes its bank at that edge. The exception is a new column command to the same bank: it replaces the pending auto-precharge with its own addr[10] choice.
- R12: Under reset every output is zero: both banks closed, rows, mode fields, cmd_code and err_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | 11 | Row, column, op-code; bit 10 selects auto-precharge or all-bank |
| cmd_code | output | 4 | Decoded command code |
| err_pulse | output | 1 | One-cycle flag for a column access to a closed bank |
| bank_active | output | 2 | Open flag per bank |
| bank_row | output | 22 | Stored row per bank, bank 0 in the low bits |
| burst_len | output | 3 | Programmed burst length code |
| burst_interleave | output | 1 | Programmed burst type |
| cas_latency | output | 3 | Programmed read latency |

## Verification
The hardest situation to reach is a pending auto-precharge whose closing edge moves. It can move because the clock is held off mid-burst, because a burst stop cuts the burst short, or because a column command to the other bank interrupts it. The stimulus reaches each case by first loading a short burst length. It then issues an auto-precharge access and suspends, stops or interrupts it at a known beat, and it checks the bank flag on every following cycle. A full-page burst runs to its 512th beat so that the longest count is exercised. An ignored access to a closed bank is placed in the middle of a live burst, which shows that the burst kept counting.

// File: rtl/sdc_pkg.sv
// Shared command encoding for the SDRAM command decoder and bank tracker.
package sdc_pkg;

    typedef enum logic [3:0] {
        C_NOP      = 4'd0,
        C_ACT      = 4'd1,
        C_READ     = 4'd2,
        C_WRITE    = 4'd3,
        C_PRE      = 4'd4,
        C_PREALL   = 4'd5,
        C_BST      = 4'd6,
        C_AREF     = 4'd7,
        C_SREF_IN  = 4'd8,
        C_PDN_IN   = 4'd9,
        C_SUSP_IN  = 4'd10,
        C_LP_EXIT  = 4'd11,
        C_LP_HOLD  = 4'd12,
        C_MRS      = 4'd13,
        C_READ_AP  = 4'd14,
        C_WRITE_AP = 4'd15
    } cmd_e;

endpackage

// File: rtl/sdc_decode.sv
// sdc_decode: classifies the pin state at each rising edge into a cmd_e code.
// It keeps the previous clock-enable value, so it can tell refresh from
// self-refresh and spot low-power entry and exit.
// Assumes: any_active comes from registered bank state, so no combinational loop forms.
module sdc_decode
    import sdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap,
    input  logic any_active,
    output cmd_e cmd,
    output logic normal,
    output cmd_e cmd_q
);

    logic       cke_q;
    logic [2:0] pins;

    // Purpose: remember clock-enable from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    // Purpose: classify the current edge from the clock-enable pair and the strobes.
    always_comb begin
        pins   = {ras_n, cas_n, we_n};
        normal = cke_q && cke;
        cmd    = C_NOP;
        if (!cke_q) begin
            cmd = cke ? C_LP_EXIT : C_LP_HOLD;
        end else if (!cke) begin
            if (!cs_n && pins == 3'b001) cmd = C_SREF_IN;
            else if (any_active)         cmd = C_SUSP_IN;
            else                         cmd = C_PDN_IN;
        end else if (!cs_n) begin
            case (pins)
                3'b000:  cmd = C_MRS;
                3'b011:  cmd = C_ACT;
                3'b101:  cmd = ap ? C_READ_AP  : C_READ;
                3'b100:  cmd = ap ? C_WRITE_AP : C_WRITE;
                3'b010:  cmd = ap ? C_PREALL   : C_PRE;
                3'b110:  cmd = C_BST;
                3'b001:  cmd = C_AREF;
                default: cmd = C_NOP;
            endcase
        end
    end

    // Purpose: register the decoded code for the output.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= C_NOP;
        else        cmd_q <= cmd;
    end

    a_r2_deselect_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_q && cke && cs_n) |=> (cmd_q == C_NOP));

    a_r4_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_q && !cke) |=> (cmd_q == C_LP_HOLD));

endmodule

// File: rtl/sdc_mode_reg.sv
// sdc_mode_reg: holds the burst length, burst type and read latency fields
// that a mode-load command programs.
// Assumes: op carries addr[6:0] as sampled with the command.
module sdc_mode_reg
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cmd_e       cmd,
    input  logic [6:0] op,
    output logic [2:0] bl_code,
    output logic       bt,
    output logic [2:0] cl
);

    // Purpose: capture the op-code fields on a mode load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_code <= '0;
            bt      <= 1'b0;
            cl      <= '0;
        end else if (cmd == C_MRS) begin
            bl_code <= op[2:0];
            bt      <= op[3];
            cl      <= op[6:4];
        end
    end

    a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != C_MRS) |=> $stable({cl, bt, bl_code}));

endmodule

// File: rtl/sdc_bank_ctrl.sv
// sdc_bank_ctrl: per-bank open flags and rows, plus one shared burst tracker
// that closes a bank at the end of an auto-precharge burst.
// Assumes: one burst at a time; PAGE_LEN >= 8; a pending close is applied
// before the current command is checked against the bank flags.
module sdc_bank_ctrl
    import sdc_pkg::*;
#(
    parameter  int NBANK    = 2,
    parameter  int ROW_W    = 11,
    parameter  int PAGE_LEN = 512,
    localparam int BA_W     = $clog2(NBANK),
    localparam int CNT_W    = $clog2(PAGE_LEN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  cmd_e                   cmd,
    input  logic                   normal,
    input  logic [BA_W-1:0]        ba,
    input  logic [ROW_W-1:0]       row_addr,
    input  logic [2:0]             bl_code,
    output logic [NBANK-1:0]       active,
    output logic [NBANK*ROW_W-1:0] rows,
    output logic                   err
);

    logic             busy, ap_pend;
    logic [CNT_W-1:0] left;
    logic [BA_W-1:0]  ap_bank;
    logic             is_col, col_ap, nat_end, accept, err_d, stop;
    logic [NBANK-1:0] ap_mask, eff, close_int, act_d;

    // Purpose: map a burst length code to the index of its last beat.
    function automatic logic [CNT_W-1:0] last_idx(input logic [2:0] code);
        case (code)
            3'd1:    return CNT_W'(1);
            3'd2:    return CNT_W'(3);
            3'd3:    return CNT_W'(7);
            3'd7:    return CNT_W'(PAGE_LEN - 1);
            default: return '0;
        endcase
    endfunction

    // Purpose: work out burst end, acceptance, error and the next bank flags.
    always_comb begin
        is_col    = cmd inside {C_READ, C_READ_AP, C_WRITE, C_WRITE_AP};
        col_ap    = cmd inside {C_READ_AP, C_WRITE_AP};
        stop      = (cmd == C_BST);
        ap_mask   = NBANK'(1) << ap_bank;
        nat_end   = busy && normal && (left == '0);
        eff       = active & ~((nat_end && ap_pend) ? ap_mask : '0);
        accept    = is_col && eff[ba];
        err_d     = is_col && !eff[ba];
        close_int = (busy && !nat_end && ap_pend &&
                     (stop || (accept && ap_bank != ba))) ? ap_mask : '0;
        act_d     = eff & ~close_int;
        case (cmd)
            C_ACT:    act_d[ba] = 1'b1;
            C_PRE:    act_d[ba] = 1'b0;
            C_PREALL: act_d     = '0;
            default:  ;
        endcase
    end

    // Purpose: register the bank flags and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
            err    <= 1'b0;
        end else begin
            active <= act_d;
            err    <= err_d;
        end
    end

    // Purpose: start, count, pause and end the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            ap_pend <= 1'b0;
            left    <= '0;
            ap_bank <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            left    <= last_idx(bl_code);
            ap_pend <= col_ap;
            ap_bank <= ba;
        end else if (stop || nat_end) begin
            busy    <= 1'b0;
            ap_pend <= 1'b0;
        end else begin
            if (busy && normal) left <= left - 1'b1;
            if (ap_pend && (cmd == C_PREALL || (cmd == C_PRE && ba == ap_bank)))
                ap_pend <= 1'b0;
        end
    end

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        logic [ROW_W-1:0] row_q;

        // Purpose: store the row opened in this bank.
        always_ff @(posedge clk) begin
            if (!rst_n)                                row_q <= '0;
            else if (cmd == C_ACT && ba == BA_W'(i))  row_q <= row_addr;
        end
        assign rows[i*ROW_W +: ROW_W] = row_q;

        a_r5_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == C_ACT && ba == BA_W'(i)) |=> active[i]);

        a_r6_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == C_PRE && ba == BA_W'(i)) |=> !active[i]);
    end

    a_r6_preall_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == C_PREALL) |=> (active == '0));

    a_r7_closed_access_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !active[ba]) |=> err);

    a_r4_lowpower_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd inside {C_LP_HOLD, C_LP_EXIT, C_PDN_IN, C_SUSP_IN, C_SREF_IN})
        |=> ($stable(active) && $stable(rows)));

endmodule

// File: rtl/sdram_cmd_tracker.sv
// sdram_cmd_tracker: device-side SDRAM command decoder with two-bank state,
// mode fields and an error pulse for column access to a closed bank.
// Assumes: ADDR_W >= 11 (bit AP_BIT is the auto-precharge / all-bank flag,
// and bits 6:0 carry the mode op-code); all outputs are registered.
module sdram_cmd_tracker
    import sdc_pkg::*;
#(
    parameter  int NBANK    = 2,
    parameter  int ADDR_W   = 11,
    parameter  int AP_BIT   = 10,
    parameter  int PAGE_LEN = 512,
    localparam int BA_W     = $clog2(NBANK)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke,
    input  logic                    cs_n,
    input  logic                    ras_n,
    input  logic                    cas_n,
    input  logic                    we_n,
    input  logic [BA_W-1:0]         ba,
    input  logic [ADDR_W-1:0]       addr,
    output logic [3:0]              cmd_code,
    output logic                    err_pulse,
    output logic [NBANK-1:0]        bank_active,
    output logic [NBANK*ADDR_W-1:0] bank_row,
    output logic [2:0]              burst_len,
    output logic                    burst_interleave,
    output logic [2:0]              cas_latency
);

    cmd_e cmd, cmd_q;
    logic normal;

    sdc_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .ap         (addr[AP_BIT]),
        .any_active (|bank_active),
        .cmd        (cmd),
        .normal     (normal),
        .cmd_q      (cmd_q)
    );

    sdc_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .op      (addr[6:0]),
        .bl_code (burst_len),
        .bt      (burst_interleave),
        .cl      (cas_latency)
    );

    sdc_bank_ctrl #(
        .NBANK    (NBANK),
        .ROW_W    (ADDR_W),
        .PAGE_LEN (PAGE_LEN)
    ) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .normal   (normal),
        .ba       (ba),
        .row_addr (addr),
        .bl_code  (burst_len),
        .active   (bank_active),
        .rows     (bank_row),
        .err      (err_pulse)
    );

    assign cmd_code = cmd_q;

endmodule

// File: tb/sdram_cmd_tracker_test.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_test;

    localparam logic [3:0] P_DES = 4'b1111, P_MRS = 4'b0000, P_ACT = 4'b0011,
                           P_RD  = 4'b0101, P_WR  = 4'b0100, P_PRE = 4'b0010,
                           P_BST = 4'b0110, P_REF = 4'b0001;
    localparam logic [3:0] K_NOP = 0, K_ACT = 1, K_RD = 2, K_WR = 3, K_PRE = 4,
                           K_PREA = 5, K_BST = 6, K_REF = 7, K_SRE = 8,
                           K_PDN = 9, K_SUS = 10, K_EXIT = 11, K_HOLD = 12,
                           K_MRS = 13, K_RDA = 14, K_WRA = 15;
    localparam logic [10:0] APB = 11'h400;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        ba = 1'b0;
    logic [10:0] addr = '0;
    logic [3:0]  cmd_code;
    logic        err_pulse, burst_interleave;
    logic [1:0]  bank_active;
    logic [21:0] bank_row;
    logic [2:0]  burst_len, cas_latency;

    sdram_cmd_tracker uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .cmd_code(cmd_code), .err_pulse(err_pulse), .bank_active(bank_active),
        .bank_row(bank_row), .burst_len(burst_len),
        .burst_interleave(burst_interleave), .cas_latency(cas_latency)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [3:0]  cmd;
        logic        err;
        logic [1:0]  act;
        logic [10:0] r0, r1;
        logic [6:0]  mode;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          vectors = 0, fails = 0;
    bit          done = 1'b0;
    logic [1:0]  e_act = '0;
    logic [10:0] e_r0 = '0, e_r1 = '0;
    logic [6:0]  e_mode = '0;

    // Driver: apply one edge's pins and queue what the outputs must be after it.
    task automatic step(input logic k, input logic [3:0] p, input logic b,
                        input logic [10:0] a, input logic [3:0] ec,
                        input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        cke = k; {cs_n, ras_n, cas_n, we_n} = p; ba = b; addr = a;
        e.cmd = ec; e.err = ee; e.act = e_act; e.r0 = e_r0; e.r1 = e_r1;
        e.mode = e_mode; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic nop(input string tag);
        step(1'b1, P_DES, 1'b0, 11'h000, K_NOP, 1'b0, tag);
    endtask

    // Monitor: compare outputs shortly after each edge against the queue head.
    always @(posedge clk) begin : mon
        exp_t e;
        #1;
        if (sb.size() != 0) begin
            e = sb.pop_front();
            vectors++;
            if (cmd_code !== e.cmd || err_pulse !== e.err || bank_active !== e.act ||
                bank_row !== {e.r1, e.r0} ||
                {cas_latency, burst_interleave, burst_len} !== e.mode) begin
                fails++;
                $display("FAIL %s: actual cmd=%0d err=%b act=%b rows=%h mode=%h expected cmd=%0d err=%b act=%b rows=%h mode=%h",
                         e.tag, cmd_code, err_pulse, bank_active, bank_row,
                         {cas_latency, burst_interleave, burst_len},
                         e.cmd, e.err, e.act, {e.r1, e.r0}, e.mode);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual run still going, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R12: reset state
        step(1'b1, P_DES, 1'b0, 11'h000, K_NOP, 1'b0, "R12 reset");
        rst_n = 1'b1;

        // R10: mode load CL=2, sequential, BL=4
        e_mode = 7'h22;
        step(1'b1, P_MRS, 1'b0, 11'h022, K_MRS, 1'b0, "R10 mode load");
        // R2: deselected mode-load pattern is ignored
        step(1'b1, 4'b1000, 1'b0, 11'h07F, K_NOP, 1'b0, "R2 deselect");
        // R7: read to closed bank
        step(1'b1, P_RD, 1'b0, 11'h000, K_RD, 1'b1, "R7 read idle bank");
        // R5: activations
        e_act = 2'b01; e_r0 = 11'h155;
        step(1'b1, P_ACT, 1'b0, 11'h155, K_ACT, 1'b0, "R5 act bank0");
        e_act = 2'b11; e_r1 = 11'h2AA;
        step(1'b1, P_ACT, 1'b1, 11'h2AA, K_ACT, 1'b0, "R5 act bank1");
        // R6: single-bank precharge
        e_act = 2'b01;
        step(1'b1, P_PRE, 1'b1, 11'h000, K_PRE, 1'b0, "R6 pre bank1");
        // R7: write to closed bank
        step(1'b1, P_WR, 1'b1, 11'h000, K_WR, 1'b1, "R7 write idle bank");
        // R8: read with auto-precharge, BL=4
        step(1'b1, P_RD, 1'b0, APB | 11'h010, K_RDA, 1'b0, "R8 read ap");
        nop("R8 beat2"); nop("R8 beat3"); nop("R8 beat4");
        e_act = 2'b00;
        nop("R8 closed");
        // R6: precharge all
        e_act = 2'b01; e_r0 = 11'h0F0;
        step(1'b1, P_ACT, 1'b0, 11'h0F0, K_ACT, 1'b0, "R5 act bank0");
        e_act = 2'b11; e_r1 = 11'h00F;
        step(1'b1, P_ACT, 1'b1, 11'h00F, K_ACT, 1'b0, "R5 act bank1");
        e_act = 2'b00;
        step(1'b1, P_PRE, 1'b0, APB, K_PREA, 1'b0, "R6 pre all");
        // R1 / R3: refresh and self-refresh
        step(1'b1, P_REF, 1'b0, 11'h000, K_REF, 1'b0, "R3 auto refresh");
        step(1'b0, P_REF, 1'b0, 11'h000, K_SRE, 1'b0, "R3 self refresh in");
        step(1'b0, P_DES, 1'b0, 11'h000, K_HOLD, 1'b0, "R4 hold");
        step(1'b1, P_DES, 1'b0, 11'h000, K_EXIT, 1'b0, "R4 exit");
        // R4: power-down with idle banks; activate during hold ignored
        step(1'b0, P_DES, 1'b0, 11'h000, K_PDN, 1'b0, "R4 power-down in");
        step(1'b0, P_ACT, 1'b0, 11'h123, K_HOLD, 1'b0, "R4 act ignored");
        step(1'b1, P_DES, 1'b0, 11'h000, K_EXIT, 1'b0, "R4 exit");
        // R4: clock suspend with an open bank; activate on entry ignored
        e_act = 2'b01; e_r0 = 11'h011;
        step(1'b1, P_ACT, 1'b0, 11'h011, K_ACT, 1'b0, "R5 act bank0");
        step(1'b0, P_ACT, 1'b1, 11'h321, K_SUS, 1'b0, "R4 suspend in");
        step(1'b1, P_DES, 1'b0, 11'h000, K_EXIT, 1'b0, "R4 exit");
        // R9: BL=2 burst paused by clock suspend
        e_mode = 7'h21;
        step(1'b1, P_MRS, 1'b0, 11'h021, K_MRS, 1'b0, "R10 mode load");
        step(1'b1, P_WR, 1'b0, APB, K_WRA, 1'b0, "R9 write ap");
        step(1'b0, P_DES, 1'b0, 11'h000, K_SUS, 1'b0, "R9 suspend in");
        step(1'b0, P_DES, 1'b0, 11'h000, K_HOLD, 1'b0, "R9 paused");
        step(1'b1, P_DES, 1'b0, 11'h000, K_EXIT, 1'b0, "R9 exit");
        nop("R9 beat2");
        e_act = 2'b00;
        nop("R9 closed after pause");
        // R11: burst stop closes pending auto-precharge bank (BL=8)
        e_mode = 7'h33;
        step(1'b1, P_MRS, 1'b0, 11'h033, K_MRS, 1'b0, "R10 mode load");
        e_act = 2'b01; e_r0 = 11'h001;
        step(1'b1, P_ACT, 1'b0, 11'h001, K_ACT, 1'b0, "R5 act bank0");
        e_act = 2'b11; e_r1 = 11'h002;
        step(1'b1, P_ACT, 1'b1, 11'h002, K_ACT, 1'b0, "R5 act bank1");
        step(1'b1, P_RD, 1'b0, APB, K_RDA, 1'b0, "R11 read ap b0");
        nop("R11 mid burst");
        e_act = 2'b10;
        step(1'b1, P_BST, 1'b0, 11'h000, K_BST, 1'b0, "R11 stop closes b0");
        // R11: interruption by other bank closes pending bank; R7 ignored access mid-burst
        step(1'b1, P_RD, 1'b1, APB, K_RDA, 1'b0, "R11 read ap b1");
        nop("R11 mid burst");
        step(1'b1, P_WR, 1'b0, 11'h000, K_WR, 1'b1, "R7 ignored mid burst");
        e_act = 2'b11; e_r0 = 11'h003;
        step(1'b1, P_ACT, 1'b0, 11'h003, K_ACT, 1'b0, "R5 act bank0");
        e_act = 2'b01;
        step(1'b1, P_WR, 1'b0, 11'h000, K_WR, 1'b0, "R11 interrupt closes b1");
        for (int i = 0; i < 8; i++) nop("R11 no ap keeps b0");
        // R11: same-bank column command replaces the pending auto-precharge
        step(1'b1, P_RD, 1'b0, APB, K_RDA, 1'b0, "R11 read ap b0");
        step(1'b1, P_RD, 1'b0, 11'h000, K_RD, 1'b0, "R11 replace ap");
        for (int i = 0; i < 10; i++) nop("R11 b0 stays open");
        // R9: full-page burst with auto-precharge
        e_mode = 7'h07;
        step(1'b1, P_MRS, 1'b0, 11'h007, K_MRS, 1'b0, "R10 mode load");
        step(1'b1, P_WR, 1'b0, APB, K_WRA, 1'b0, "R9 full page write ap");
        for (int i = 0; i < 511; i++) nop("R9 full page open");
        e_act = 2'b00;
        nop("R9 full page closed");
        // R9: reserved length code acts as single beat
        e_mode = 7'h05;
        step(1'b1, P_MRS, 1'b0, 11'h005, K_MRS, 1'b0, "R10 mode load");
        e_act = 2'b01; e_r0 = 11'h004;
        step(1'b1, P_ACT, 1'b0, 11'h004, K_ACT, 1'b0, "R5 act bank0");
        step(1'b1, P_RD, 1'b0, APB, K_RDA, 1'b0, "R9 reserved code read ap");
        e_act = 2'b00;
        nop("R9 single beat closed");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule